// File: doc/BRIEF.md
# ALU Status and Control Flags Register

This block combines a small 8/16-bit arithmetic and logic unit with a flags register of the kind a processor keeps beside its accumulator. On every cycle where `updateEn` is high, it computes the selected operation on the two operands. It then registers the result together with six status flags: carry, parity, auxiliary carry, zero, sign and overflow.

Three control flags sit in the same word: interrupt enable, trap and direction. They change only through explicit per-bit set and clear commands. The block stores them and drives them out, and nothing inside it acts on them.

A narrow mode works on the low byte of each operand. In that mode every flag is judged at 8 bits and the upper byte of the result reads zero. Outputs change one clock edge after the inputs that cause them.

Top module: `aluFlagUnit`

## Requirements
- R1: After an active-low reset on `rstN`, `result` and every bit of `flags` read 0.
- R2: `opCode` selects the operation: 0 add, 1 add with carry-in, 2 subtract, 3 subtract with borrow-in (carryIn is the borrow), 4 AND, 5 OR, 6 XOR, 7 NOT of opA. `wideOp`=1 operates on 16 bits. `wideOp`=0 operates on bits 7:0 only, and bits 15:8 of `result` are 0. `result` is registered and appears one cycle after `updateEn` is high.
- R3: Carry (flags bit 0) is 1 when an add produces a carry out of the selected width, or when a subtract needs a borrow (unsigned opA < opB + borrow-in).
- R4: Overflow (flags bit 5) is 1 when the signed result of an add or subtract cannot be represented at the selected width.
- R5: Sign (flags bit 4) equals the most significant bit of the result at the selected width (bit 15 or bit 7).
- R6: Zero (flags bit 3) is 1 exactly when the result at the selected width is all zeros.
- R7: Auxiliary carry (flags bit 2) is 1 when an add carries from bit 3 into bit 4, or when a subtract borrows into bit 3 (low nibble of opA < low nibble of opB plus borrow-in).
- R8: Parity (flags bit 1) is 1 when the result at the selected width has an odd number of one bits, and 0 when the count is even.
- R9: Logic operations (codes 4 to 7) force carry and overflow to 0, update sign, zero and parity from their result, and leave auxiliary carry at its previous value.
- R10: While `updateEn` is 0, `result` and all six status flags hold their values whatever the operands, carry-in and operation code are.
- R11: `ctlSet`/`ctlClr` bit 0 drives interrupt enable (flags bit 7, 1 = enabled), bit 1 drives trap (flags bit 6), and bit 2 drives direction (flags bit 8, 0 = incrementing, 1 = decrementing). A set takes effect on the next edge, and a clear does the same. When set and clear arrive together, set wins. Without a command the bit holds, independent of `updateEn`.
- R12: Control commands never change `result` or the status flags, and operations never change the control flags. Both kinds may act in the same cycle.
- R13: `flags` bits 15:9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry or borrow input for codes 1 and 3 |
| opCode | input | 3 | Operation select |
| wideOp | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| updateEn | input | 1 | Registers result and status flags this cycle |
| ctlSet | input | 3 | Per-bit set commands for the control flags |
| ctlClr | input | 3 | Per-bit clear commands for the control flags |
| result | output | 16 | Registered operation result |
| flags | output | 16 | Packed status and control flags |

## Verification
The bench aims at the width boundaries. Cases include 0x7FFF+1 and 0x80-1 in byte mode, where a design that judged overflow or sign at the wrong bit would report the wrong flag. They also include 0xFFFF+1 and a byte add whose operands have a non-zero upper byte, where carry and zero must come from the selected width alone. Subtractions with and without borrow-in check that carry and auxiliary carry act as borrows rather than raw adder carries; an inverted sense would flip both. Logic operations that follow an arithmetic one expose a design that clears or recomputes auxiliary carry. Simultaneous set and clear commands, plus commands issued during updates, expose priority mistakes and any leak between the control and status halves.

// File: rtl/aluFlagPkg.sv
package aluFlagPkg;

  localparam int CTL_N   = 3;
  localparam int FLAGS_W = 16;

  // bit positions inside the packed flags word
  localparam int POS_CARRY  = 0;
  localparam int POS_PARITY = 1;
  localparam int POS_AUX    = 2;
  localparam int POS_ZERO   = 3;
  localparam int POS_SIGN   = 4;
  localparam int POS_OVF    = 5;
  localparam int POS_TRAP   = 6;
  localparam int POS_INTEN  = 7;
  localparam int POS_DIR    = 8;

  // control command bit order
  localparam int CTL_INTEN = 0;
  localparam int CTL_TRAP  = 1;
  localparam int CTL_DIR   = 2;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOT = 3'd7
  } aluOpE;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logicSelE;

  typedef struct packed {
    logic             loadResult;
    logic             arith;
    logic             logicOp;
    logic             subtract;
    logic             useCarry;
    logicSelE         logicSel;
    logic [CTL_N-1:0] setCtl;
    logic [CTL_N-1:0] clrCtl;
  } strobeT;

endpackage

// File: rtl/addSlice.sv
module addSlice #(
  parameter int W     = 16,
  parameter int NIB_W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         nibCarry,
  output logic         ovf
);

  logic [NIB_W:0] nibSum;

  always_comb begin
    {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    nibSum      = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    nibCarry    = nibSum[NIB_W];
    ovf         = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/flagControl.sv
module flagControl import aluFlagPkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opCode,
  input  logic             updateEn,
  input  logic [CTL_N-1:0] ctlSet,
  input  logic [CTL_N-1:0] ctlClr,
  output strobeT           stb
);

  aluOpE opSel;
  logic  isLogic;

  always_comb begin
    opSel          = aluOpE'(opCode);
    isLogic        = opSel inside {OP_AND, OP_OR, OP_XOR, OP_NOT};
    stb            = '0;
    stb.arith      = updateEn && !isLogic;
    stb.logicOp    = updateEn && isLogic;
    stb.loadResult = updateEn;
    stb.subtract   = (opSel == OP_SUB) || (opSel == OP_SBB);
    stb.useCarry   = (opSel == OP_ADC) || (opSel == OP_SBB);
    stb.logicSel   = logicSelE'(opCode[1:0]);
    stb.setCtl     = ctlSet;
    stb.clrCtl     = ctlClr;
  end

  assert_one_class_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.arith, stb.logicOp}));

  assert_idle_no_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |-> !(stb.arith || stb.logicOp));

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath import aluFlagPkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int NIB_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               carryIn,
  input  logic               wideOp,
  input  strobeT             stb,
  output logic [DATA_W-1:0]  result,
  output logic [FLAGS_W-1:0] flags
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0]   widthMask, aEff, bEff, bOper;
  logic                carryFeed;
  logic [DATA_W-1:0]   sumW;
  logic                coutW, nibW, ovfW;
  logic [NARROW_W-1:0] sumN;
  logic                coutN, nibN, ovfN;
  logic [DATA_W-1:0]   arithRes, logicRes, nextRes;
  logic                coutRaw, nibRaw, ovfRaw;
  logic                carryNext, auxNext, signNext, zeroNext, parityNext;

  logic [DATA_W-1:0]   resultQ;
  logic                carryQ, ovfQ, auxQ, signQ, zeroQ, parityQ;
  logic [CTL_N-1:0]    ctlQ;
  logic [5:0]          statusVec;

  always_comb begin
    widthMask = wideOp ? {DATA_W{1'b1}} : NARROW_MASK;
    aEff      = opA & widthMask;
    bEff      = opB & widthMask;
    bOper     = stb.subtract ? ~bEff : bEff;
    carryFeed = (stb.useCarry & carryIn) ^ stb.subtract;
  end

  addSlice #(.W(DATA_W), .NIB_W(NIB_W)) i_wideSlice (
    .a(aEff), .b(bOper), .cin(carryFeed),
    .sum(sumW), .cout(coutW), .nibCarry(nibW), .ovf(ovfW)
  );

  addSlice #(.W(NARROW_W), .NIB_W(NIB_W)) i_narrowSlice (
    .a(aEff[NARROW_W-1:0]), .b(bOper[NARROW_W-1:0]), .cin(carryFeed),
    .sum(sumN), .cout(coutN), .nibCarry(nibN), .ovf(ovfN)
  );

  always_comb begin
    if (wideOp) begin
      arithRes = sumW;
      coutRaw  = coutW;
      nibRaw   = nibW;
      ovfRaw   = ovfW;
    end else begin
      arithRes = {{(DATA_W-NARROW_W){1'b0}}, sumN};
      coutRaw  = coutN;
      nibRaw   = nibN;
      ovfRaw   = ovfN;
    end
    // adder carry of a subtract is the inverse of a borrow
    carryNext = coutRaw ^ stb.subtract;
    auxNext   = nibRaw ^ stb.subtract;

    unique case (stb.logicSel)
      LG_AND:  logicRes = aEff & bEff;
      LG_OR:   logicRes = aEff | bEff;
      LG_XOR:  logicRes = aEff ^ bEff;
      default: logicRes = ~aEff;
    endcase
    logicRes = logicRes & widthMask;

    nextRes    = stb.logicOp ? logicRes : arithRes;
    signNext   = wideOp ? nextRes[DATA_W-1] : nextRes[NARROW_W-1];
    zeroNext   = (nextRes == '0);
    parityNext = ^nextRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      carryQ  <= 1'b0;
      ovfQ    <= 1'b0;
      auxQ    <= 1'b0;
      signQ   <= 1'b0;
      zeroQ   <= 1'b0;
      parityQ <= 1'b0;
    end else begin
      if (stb.loadResult) begin
        resultQ <= nextRes;
        signQ   <= signNext;
        zeroQ   <= zeroNext;
        parityQ <= parityNext;
      end
      if (stb.arith) begin
        carryQ <= carryNext;
        ovfQ   <= ovfRaw;
        auxQ   <= auxNext;
      end else if (stb.logicOp) begin
        carryQ <= 1'b0;
        ovfQ   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else begin
      for (int i = 0; i < CTL_N; i++) begin
        if (stb.setCtl[i])      ctlQ[i] <= 1'b1;
        else if (stb.clrCtl[i]) ctlQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    flags             = '0;
    flags[POS_CARRY]  = carryQ;
    flags[POS_PARITY] = parityQ;
    flags[POS_AUX]    = auxQ;
    flags[POS_ZERO]   = zeroQ;
    flags[POS_SIGN]   = signQ;
    flags[POS_OVF]    = ovfQ;
    flags[POS_INTEN]  = ctlQ[CTL_INTEN];
    flags[POS_TRAP]   = ctlQ[CTL_TRAP];
    flags[POS_DIR]    = ctlQ[CTL_DIR];
    result            = resultQ;
    statusVec         = {carryQ, ovfQ, auxQ, signQ, zeroQ, parityQ};
  end

  assert_hold_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.arith || stb.logicOp) |=> $stable(statusVec) && $stable(resultQ));

  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.logicOp |=> !carryQ && !ovfQ);

  assert_logic_keeps_aux_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.logicOp |=> auxQ == $past(auxQ));

  assert_zero_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadResult |=> zeroQ == (resultQ == '0));

  assert_parity_odd_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadResult |=> (parityQ ? 1 : 0) == ($countones(resultQ) % 2));

  assert_sign_msb_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadResult |=> signQ == ($past(wideOp) ? resultQ[DATA_W-1] : resultQ[NARROW_W-1]));

  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadResult && !wideOp) |=> resultQ[DATA_W-1:NARROW_W] == '0);

  generate
    for (genvar g = 0; g < CTL_N; g++) begin : g_ctlChk
      assert_ctl_set_R11: assert property (@(posedge clk) disable iff (!rstN)
        stb.setCtl[g] |=> ctlQ[g]);
      assert_ctl_clr_R11: assert property (@(posedge clk) disable iff (!rstN)
        (stb.clrCtl[g] && !stb.setCtl[g]) |=> !ctlQ[g]);
      assert_ctl_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
        !(stb.setCtl[g] || stb.clrCtl[g]) |=> $stable(ctlQ[g]));
    end
  endgenerate

endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit import aluFlagPkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               carryIn,
  input  logic [2:0]         opCode,
  input  logic               wideOp,
  input  logic               updateEn,
  input  logic [CTL_N-1:0]   ctlSet,
  input  logic [CTL_N-1:0]   ctlClr,
  output logic [DATA_W-1:0]  result,
  output logic [FLAGS_W-1:0] flags
);

  strobeT stb;

  flagControl i_flagControl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .updateEn(updateEn),
    .ctlSet(ctlSet), .ctlClr(ctlClr), .stb(stb)
  );

  aluDatapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_aluDatapath (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .wideOp(wideOp), .stb(stb), .result(result), .flags(flags)
  );

  assert_upper_flags_zero_R13: assert property (@(posedge clk) disable iff (!rstN)
    flags[FLAGS_W-1:9] == '0);

endmodule

// File: tb/test_aluFlagUnit.sv
module test_aluFlagUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wideOp = 1'b0;
  logic        updateEn = 1'b0;
  logic [2:0]  ctlSet = '0, ctlClr = '0;
  logic [15:0] result, flags;

  int total = 0;
  int bad   = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  // model state
  int mRes = 0;
  bit mC, mP, mA, mZ, mS, mO;
  bit [2:0] mCtl;

  always #2 clk = ~clk;

  aluFlagUnit i_aluFlagUnit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .opCode(opCode), .wideOp(wideOp), .updateEn(updateEn),
    .ctlSet(ctlSet), .ctlClr(ctlClr), .result(result), .flags(flags)
  );

  function automatic logic [15:0] packFlags();
    logic [15:0] f;
    f = '0;
    f[0] = mC; f[1] = mP; f[2] = mA; f[3] = mZ; f[4] = mS; f[5] = mO;
    f[6] = mCtl[1]; f[7] = mCtl[0]; f[8] = mCtl[2];
    return f;
  endfunction

  task automatic check(input string tag, input logic [15:0] gotR, gotF, expR, expF);
    total++;
    if (gotR !== expR || gotF !== expF) begin
      bad++;
      $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
               tag, gotR, gotF, expR, expF);
    end
  endtask

  task automatic drive(input int op, input int a, input int b, input bit cin,
                       input bit wide, input bit upd, input bit [2:0] s,
                       input bit [2:0] c, input string tag);
    int w, mask, av, bv, cv, r, t, msbA, msbB, msbR;
    @(negedge clk);
    opA = a[15:0]; opB = b[15:0]; carryIn = cin; opCode = op[2:0];
    wideOp = wide; updateEn = upd; ctlSet = s; ctlClr = c;
    if (upd) begin
      w = wide ? 16 : 8;
      mask = (1 << w) - 1;
      av = a & mask; bv = b & mask;
      cv = (op == 1 || op == 3) ? int'(cin) : 0;
      msbA = (av >> (w - 1)) & 1;
      msbB = (bv >> (w - 1)) & 1;
      if (op <= 1) begin
        t = av + bv + cv;
        r = t & mask;
        mC = t > mask;
        mA = ((av & 15) + (bv & 15) + cv) > 15;
        msbR = (r >> (w - 1)) & 1;
        mO = (msbA == msbB) && (msbR != msbA);
      end else if (op <= 3) begin
        t = av - bv - cv;
        r = t & mask;
        mC = t < 0;
        mA = ((av & 15) - (bv & 15) - cv) < 0;
        msbR = (r >> (w - 1)) & 1;
        mO = (msbA != msbB) && (msbR != msbA);
      end else begin
        case (op)
          4: r = av & bv;
          5: r = av | bv;
          6: r = av ^ bv;
          default: r = (~av) & mask;
        endcase
        mC = 0; mO = 0;
      end
      mRes = r;
      mS = ((r >> (w - 1)) & 1) == 1;
      mZ = (r == 0);
      mP = ($countones(r[15:0]) % 2) == 1;
    end
    for (int i = 0; i < 3; i++) begin
      if (s[i]) mCtl[i] = 1'b1;
      else if (c[i]) mCtl[i] = 1'b0;
    end
    expQ.push_back({mRes[15:0], packFlags()});
    tagQ.push_back(tag);
  endtask

  // monitor: compares one cycle after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [31:0] e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        check(tg, result, flags, e[31:16], e[15:0]);
      end
    end
  end

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", result, flags, 16'h0000, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 R13 after release", result, flags, 16'h0000, 16'h0000);

    // R2 R3 R4 R5 R7 R8: signed overflow at 16 bits
    drive(0, 16'h7FFF, 16'h0001, 0, 1, 1, 0, 0, "R4 R5 R7 add 7FFF+1");
    // R3 R6: unsigned wrap to zero
    drive(0, 16'hFFFF, 16'h0001, 0, 1, 1, 0, 0, "R3 R6 add FFFF+1");
    // R2: byte mode ignores upper operand bits
    drive(0, 16'h12FF, 16'h3401, 0, 0, 1, 0, 0, "R2 R3 byte add upper ignored");
    drive(1, 16'h007F, 16'h0000, 1, 0, 1, 0, 0, "R4 byte adc 7F+0+1");
    drive(1, 16'h1000, 16'h0FFF, 1, 1, 1, 0, 0, "R7 adc nibble carry");
    // R3 borrow
    drive(2, 16'h0000, 16'h0001, 0, 1, 1, 0, 0, "R3 R8 sub 0-1");
    drive(2, 16'h0080, 16'h0001, 0, 0, 1, 0, 0, "R4 R7 byte sub 80-1");
    drive(3, 16'h0005, 16'h0005, 1, 1, 1, 0, 0, "R3 sbb 5-5-1");
    drive(3, 16'h0010, 16'h0001, 0, 1, 1, 0, 0, "R7 sbb no borrow-in");
    // R9 logic after arithmetic leaves aux
    drive(2, 16'h0010, 16'h0001, 0, 1, 1, 0, 0, "R7 set aux");
    drive(4, 16'hF0F0, 16'h0FF0, 0, 1, 1, 0, 0, "R9 and keeps aux");
    drive(5, 16'h8000, 16'h0001, 0, 1, 1, 0, 0, "R9 or");
    drive(6, 16'h00FF, 16'h00FF, 0, 1, 1, 0, 0, "R9 R6 xor zero");
    drive(7, 16'hAB0F, 16'h0000, 0, 0, 1, 0, 0, "R9 R2 byte not");
    drive(7, 16'h0000, 16'h0000, 0, 1, 1, 0, 0, "R9 R5 wide not");
    // R10: inputs ignored without update
    drive(0, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, "R10 hold add");
    drive(2, 16'h0000, 16'h1234, 1, 0, 0, 0, 0, "R10 hold sub");
    // R11 control commands
    drive(0, 0, 0, 0, 1, 0, 3'b001, 0, "R11 set inten");
    drive(0, 0, 0, 0, 1, 0, 3'b110, 0, "R11 set trap dir");
    drive(0, 0, 0, 0, 1, 0, 0, 3'b010, "R11 clear trap");
    drive(0, 0, 0, 0, 1, 0, 3'b011, 3'b111, "R11 set wins");
    drive(0, 0, 0, 0, 1, 0, 0, 3'b111, "R11 clear all");
    // R12 commands with operations in the same cycle
    drive(0, 16'h8000, 16'h8000, 0, 1, 1, 3'b101, 0, "R12 add with set");
    drive(4, 16'h0001, 16'h0003, 0, 1, 1, 0, 3'b001, "R12 and with clear");
    drive(6, 16'h1234, 16'h4321, 0, 1, 0, 3'b010, 0, "R12 set only no status change");

    for (int k = 0; k < 400; k++) begin
      drive(int'($urandom_range(0, 7)), int'($urandom & 32'hFFFF),
            int'($urandom & 32'hFFFF), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
            3'($urandom_range(0, 7) & $urandom_range(0, 7)),
            3'($urandom_range(0, 7) & $urandom_range(0, 7)),
            "R3 R4 R7 R8 R11 random");
    end

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule